// File: doc/BRIEF.md
# Multiplexed GPIO Pin Controller

This block controls a bank of 32 I/O lines from a simple word-addressed register bus with an address, a write strobe, write data and combinational read data. Each line can be owned either by the controller's own general-purpose logic or by one of two on-chip peripherals, called A and B. Every control state has its own status register. That status is changed through a pair of write-only registers: one sets the bits written as 1, and the other clears them.

The block combines the ownership, peripheral selection, output-enable and output-level state with the output requests of the two peripherals. From these it produces, for each pin, the final drive enable, drive level and pull-up enable. The pin input goes straight to both peripherals. It also passes through a two-flop synchronizer into a readable pin-level register.

The set of lines that carry a peripheral at all is a parameter, and so is the reset owner of each line. Lines without a peripheral always report general-purpose ownership.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: Register map (word addresses): 0 own-take, 1 own-release, 2 own-status, 3 pick-A, 4 pick-B, 5 pick-status, 6 drive-on, 7 drive-off, 8 drive-status, 9 level-high, 10 level-low, 11 level-status, 12 pull-on, 13 pull-off, 14 pull-status, 15 pin-level. Writing 1s to pull-on clears pull-status bits, and writing 1s to pull-off sets them. `pin_pu_en` is the inverse of pull-status, and pull-status resets to 0 (all pull-ups active). These writes act whatever the rest of the pin's configuration is.
- R2: Writing 1s to own-take sets own-status bits, and writing 1s to own-release clears them. A status bit of 1 means the general-purpose logic owns the pin; 0 means the selected peripheral owns it.
- R3: For a line whose bit in `MUXED_MASK` is 0, writes to own-take and own-release have no effect, and its own-status bit always reads 1.
- R4: Own-status resets to `OWN_RST | ~MUXED_MASK`, so chosen lines can leave reset under peripheral control.
- R5: Writing 1s to pick-B sets pick-status bits, and writing 1s to pick-A clears them. A bit of 0 selects peripheral A and 1 selects B. Pick-status resets to 0, and these writes take effect even while the general-purpose logic owns the line.
- R6: When own-status is 0, `pin_oe` and `pin_out` follow the selected peripheral's enable and data. When own-status is 1, they follow drive-status and level-status.
- R7: Drive-on and drive-off set and clear drive-status. Level-high and level-low set and clear level-status. Both status registers reset to 0.
- R8: `pa_in` and `pb_in` always equal `pin_in` combinationally, whatever pick-status holds.
- R9: The set/clear addresses read 0. Writes to status addresses and to the pin-level address change nothing. A set or clear write changes only the bits written as 1.
- R10: Pin-level shows `pin_in` as it was two rising clock edges earlier, through two flops that reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Level seen at each pad |
| pin_oe | output | 32 | Final drive enable per pin |
| pin_out | output | 32 | Final drive level per pin |
| pin_pu_en | output | 32 | Pull-up enable per pin |
| pa_oe | input | 32 | Peripheral A drive enable request |
| pa_out | input | 32 | Peripheral A drive level |
| pb_oe | input | 32 | Peripheral B drive enable request |
| pb_out | input | 32 | Peripheral B drive level |
| pa_in | output | 32 | Pin level delivered to peripheral A |
| pb_in | output | 32 | Pin level delivered to peripheral B |

## Verification
The bench begins with directed patterns.
- After reset, the status registers are read to separate the per-line reset owner from the default owner.
- All-ones writes to ownership are aimed at lines without a peripheral, to show that those lines ignore them.
- Pick-B is written while the general-purpose logic owns a line, to show that selection is stored separately from ownership.
- Single-edge and double-edge reads of the pin level show the depth of the synchronizer.

After these, random writes go to random addresses, including status and read-only addresses. They are mixed with random peripheral requests and pin levels. This separates set from clear, touched bits from untouched bits, and the peripheral path from the general-purpose path on every line.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN_TAKE  = 4'd0,
    A_OWN_REL   = 4'd1,
    A_OWN_STAT  = 4'd2,
    A_PICK_A    = 4'd3,
    A_PICK_B    = 4'd4,
    A_PICK_STAT = 4'd5,
    A_DRV_ON    = 4'd6,
    A_DRV_OFF   = 4'd7,
    A_DRV_STAT  = 4'd8,
    A_LVL_HI    = 4'd9,
    A_LVL_LO    = 4'd10,
    A_LVL_STAT  = 4'd11,
    A_PU_ON     = 4'd12,
    A_PU_OFF    = 4'd13,
    A_PU_STAT   = 4'd14,
    A_PIN_STAT  = 4'd15
  } reg_addr_e;

  // next state of a set/clear status register; forced bits always read 1
  function automatic logic [31:0] setclr_next(input logic [31:0] cur,
                                              input logic [31:0] set_v,
                                              input logic [31:0] clr_v,
                                              input logic [31:0] forced);
    setclr_next = ((cur | set_v) & ~clr_v) | forced;
  endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [W-1:0] FORCED  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  import gpio_mux_pkg::*;

  logic [W-1:0] q_nxt;
  logic         any_write;

  assign any_write = |(set_vec | clr_vec);

  always_comb begin
    logic [31:0] t;
    t     = setclr_next(32'(q), 32'(set_vec), 32'(clr_vec), 32'(FORCED));
    q_nxt = t[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL | FORCED;
    else        q <= q_nxt;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((q & $past(set_vec)) == $past(set_vec))); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((q & $past(clr_vec) & ~FORCED) == '0)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> $stable(q)); // R9
  AST_FORCED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (q & FORCED) == FORCED); // R3

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/gpio_out_mux.sv
module gpio_out_mux #(
  parameter int W = 32
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] pick,
  input  logic [W-1:0] drv,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pa_oe,
  input  logic [W-1:0] pa_out,
  input  logic [W-1:0] pb_oe,
  input  logic [W-1:0] pb_out,
  output logic [W-1:0] oe,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic per_oe, per_out;
    assign per_oe  = pick[i] ? pb_oe[i]  : pa_oe[i];
    assign per_out = pick[i] ? pb_out[i] : pa_out[i];
    assign oe[i]   = own[i] ? drv[i] : per_oe;
    assign dout[i] = own[i] ? lvl[i] : per_out;
  end

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl #(
  parameter int          NPIN       = 32,
  parameter logic [31:0] MUXED_MASK = 32'hFFFF_FFFF,
  parameter logic [31:0] OWN_RST    = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_oe,
  output logic [31:0] pin_out,
  output logic [31:0] pin_pu_en,
  input  logic [31:0] pa_oe,
  input  logic [31:0] pa_out,
  input  logic [31:0] pb_oe,
  input  logic [31:0] pb_out,
  output logic [31:0] pa_in,
  output logic [31:0] pb_in
);
  import gpio_mux_pkg::*;

  localparam logic [NPIN-1:0] FIXED_OWN = ~MUXED_MASK[NPIN-1:0];

  // decoded write strobes brought out as named wires
  logic [NPIN-1:0] own_set, own_clr, pick_set, pick_clr;
  logic [NPIN-1:0] drv_set, drv_clr, lvl_set, lvl_clr, pu_set, pu_clr;
  logic [NPIN-1:0] own_q, pick_q, drv_q, lvl_q, pu_q, pin_q;

  function automatic logic [NPIN-1:0] strobe(input reg_addr_e a);
    strobe = (bus_we && bus_addr == a) ? bus_wdata[NPIN-1:0] : '0;
  endfunction

  assign own_set  = strobe(A_OWN_TAKE) & MUXED_MASK[NPIN-1:0];
  assign own_clr  = strobe(A_OWN_REL)  & MUXED_MASK[NPIN-1:0];
  assign pick_set = strobe(A_PICK_B);
  assign pick_clr = strobe(A_PICK_A);
  assign drv_set  = strobe(A_DRV_ON);
  assign drv_clr  = strobe(A_DRV_OFF);
  assign lvl_set  = strobe(A_LVL_HI);
  assign lvl_clr  = strobe(A_LVL_LO);
  assign pu_set   = strobe(A_PU_OFF);
  assign pu_clr   = strobe(A_PU_ON);

  gpio_setclr_reg #(.W(NPIN), .RST_VAL(OWN_RST[NPIN-1:0]), .FORCED(FIXED_OWN)) u_own (
    .clk(clk), .rst_n(rst_n), .set_vec(own_set), .clr_vec(own_clr), .q(own_q));
  gpio_setclr_reg #(.W(NPIN), .RST_VAL('0), .FORCED('0)) u_pick (
    .clk(clk), .rst_n(rst_n), .set_vec(pick_set), .clr_vec(pick_clr), .q(pick_q));
  gpio_setclr_reg #(.W(NPIN), .RST_VAL('0), .FORCED('0)) u_drv (
    .clk(clk), .rst_n(rst_n), .set_vec(drv_set), .clr_vec(drv_clr), .q(drv_q));
  gpio_setclr_reg #(.W(NPIN), .RST_VAL('0), .FORCED('0)) u_lvl (
    .clk(clk), .rst_n(rst_n), .set_vec(lvl_set), .clr_vec(lvl_clr), .q(lvl_q));
  gpio_setclr_reg #(.W(NPIN), .RST_VAL('0), .FORCED('0)) u_pu (
    .clk(clk), .rst_n(rst_n), .set_vec(pu_set), .clr_vec(pu_clr), .q(pu_q));

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in[NPIN-1:0]), .q(pin_q));

  gpio_out_mux #(.W(NPIN)) u_mux (
    .own(own_q), .pick(pick_q), .drv(drv_q), .lvl(lvl_q),
    .pa_oe(pa_oe[NPIN-1:0]), .pa_out(pa_out[NPIN-1:0]),
    .pb_oe(pb_oe[NPIN-1:0]), .pb_out(pb_out[NPIN-1:0]),
    .oe(pin_oe[NPIN-1:0]), .dout(pin_out[NPIN-1:0]));

  assign pin_pu_en[NPIN-1:0] = ~pu_q;
  assign pa_in = pin_in;
  assign pb_in = pin_in;

  if (NPIN < 32) begin : g_pad
    assign pin_oe[31:NPIN]    = '0;
    assign pin_out[31:NPIN]   = '0;
    assign pin_pu_en[31:NPIN] = '0;
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_addr_e'(bus_addr))
      A_OWN_STAT:  bus_rdata[NPIN-1:0] = own_q;
      A_PICK_STAT: bus_rdata[NPIN-1:0] = pick_q;
      A_DRV_STAT:  bus_rdata[NPIN-1:0] = drv_q;
      A_LVL_STAT:  bus_rdata[NPIN-1:0] = lvl_q;
      A_PU_STAT:   bus_rdata[NPIN-1:0] = pu_q;
      A_PIN_STAT:  bus_rdata[NPIN-1:0] = pin_q;
      default:     bus_rdata = '0;
    endcase
  end

  // age counter so the synchronizer check never looks before reset
  logic [1:0] sync_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sync_age <= '0;
    else if (sync_age != 3) sync_age <= sync_age + 2'd1;
  end

  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_age == 2'd3) |-> (pin_q == $past(pin_in[NPIN-1:0], 2))); // R10
  AST_UNMUXED_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_q & FIXED_OWN) == FIXED_OWN)); // R3
  AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pick_set) |=> $stable(own_q)); // R5
  AST_PU_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pu_clr) |=> ((pin_pu_en[NPIN-1:0] & $past(pu_clr)) == $past(pu_clr))); // R1

endmodule

// File: tb/gpio_mux_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_bench;
  localparam logic [31:0] MUXM = 32'h00FF_FFFF;
  localparam logic [31:0] ORST = 32'hFFFF_FFFC;

  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] pin_in = 0, pin_oe, pin_out, pin_pu_en;
  logic [31:0] pa_oe = 0, pa_out = 0, pb_oe = 0, pb_out = 0, pa_in, pb_in;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_own, m_pick, m_drv, m_lvl, m_pu;

  always #2 clk = ~clk;

  gpio_mux_ctrl #(.MUXED_MASK(MUXM), .OWN_RST(ORST)) u_gpio_mux_ctrl (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_oe(input logic [31:0] own, pick, drv, aoe, boe);
    return (own & drv) | (~own & ~pick & aoe) | (~own & pick & boe);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
    case (a)
      0:  m_own  = m_own | (d & MUXM);
      1:  m_own  = m_own & ~(d & MUXM);
      3:  m_pick = m_pick & ~d;
      4:  m_pick = m_pick | d;
      6:  m_drv  = m_drv | d;
      7:  m_drv  = m_drv & ~d;
      9:  m_lvl  = m_lvl | d;
      10: m_lvl  = m_lvl & ~d;
      12: m_pu   = m_pu & ~d;
      13: m_pu   = m_pu | d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(2, v);  check({tag, " R2 own"}, v, m_own);
    rd(5, v);  check({tag, " R5 pick"}, v, m_pick);
    rd(8, v);  check({tag, " R7 drv"}, v, m_drv);
    rd(11, v); check({tag, " R7 lvl"}, v, m_lvl);
    rd(14, v); check({tag, " R1 pu"}, v, m_pu);
    check({tag, " R1 pin_pu_en"}, pin_pu_en, ~m_pu);
    check({tag, " R6 pin_oe"}, pin_oe, f_oe(m_own, m_pick, m_drv, pa_oe, pb_oe));
    check({tag, " R6 pin_out"}, pin_out, f_oe(m_own, m_pick, m_lvl, pa_out, pb_out));
    check({tag, " R8 pa_in"}, pa_in, pin_in);
    check({tag, " R8 pb_in"}, pb_in, pin_in);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    m_own = ORST | ~MUXM; m_pick = 0; m_drv = 0; m_lvl = 0; m_pu = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, R4 and R7
    rd(2, v); check("R4 own reset", v, 32'hFFFF_FFFC);
    check_all("reset");
    // R3: unmuxed lines ignore ownership writes
    wr(1, 32'hFFFF_FFFF);
    rd(2, v); check("R3 unmuxed stay 1", v, 32'hFF00_0000);
    wr(0, 32'h0000_00F0);
    rd(2, v); check("R2 take", v, 32'hFF00_00F0);
    // R5: pick while PIO-owned
    wr(4, 32'h0000_00F0);
    rd(5, v); check("R5 pick while owned", v, 32'h0000_00F0);
    // R9: set/clear addresses read zero, status writes ignored
    rd(0, v); check("R9 own-take reads 0", v, 0);
    rd(13, v); check("R9 pull-off reads 0", v, 0);
    wr(8, 32'hFFFF_FFFF); wr(14, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    check_all("R9 status write");
    // R10: two-edge synchronizer
    @(negedge clk); pin_in = 32'hA5A5_0F0F;
    @(negedge clk); rd(15, v); check("R10 after one edge", v, 0);
    @(negedge clk); rd(15, v); check("R10 after two edges", v, 32'hA5A5_0F0F);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      pa_oe = $urandom; pa_out = $urandom; pb_oe = $urandom; pb_out = $urandom;
      pin_in = $urandom;
      wr(a, $urandom);
      check_all("random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule